// File: doc/BRIEF.md
# Two-Tier Bus Arbiter

This block decides who owns a microcontroller's buses, in two independent tiers. The internal tier chooses among three on-chip masters: a DMA controller, a data-transfer controller and the CPU. Each master has a request and acknowledge handshake. The internal tier evaluates only at a bus-cycle boundary, which is marked by `cycle_end`. Once a master is acknowledged, it keeps the bus until it drops its request. A higher-priority request cannot take the bus away during that time.

The external tier decides who drives the external bus. The candidates are a memory refresh, an external bus-release request, and an external-access request from the internal master that currently holds the internal bus. External ownership is tracked apart from internal ownership. An internal-only access can therefore continue while the external bus is released or being refreshed.

All pins are plain control handshakes. No data flows through the block, so it has no valid/ready stream and no back-pressure rules.

Top module: `twotier_bus_arb`

## Requirements
- R1: At a boundary with no acknowledge held, the highest requester gets its acknowledge one clock later. The order is DMA controller, then data-transfer controller, then CPU.
- R2: Requests that arrive while `cycle_end` is low grant nothing. They are served at the first boundary that follows.
- R3: At most one of `dma_ack`, `dtc_ack` and `cpu_ack` is high in any cycle.
- R4: An acknowledge stays high while its master keeps requesting. A higher-priority request does not take the bus away.
- R5: An acknowledge falls one clock after its master drops its request. The next master is acknowledged only at a later boundary.
- R6: `int_owner` reports the internal owner with the codes CPU=0, DTC=1 and DMA=2. It reads 0 after reset. It is set at each arbitration, and falls back to 0 when an arbitration finds no requester.
- R7: When the external bus is idle, its grant goes to the highest requester one clock later. The order is refresh, then bus release, then internal external access.
- R8: At most one of `rfsh_gnt`, `brel_gnt` and `iext_gnt` is high at a time. A grant holds while its request stays high, even if a higher request arrives. It falls one clock after its request drops.
- R9: `iext_req` counts only while an internal acknowledge is high. At any other time it grants nothing.
- R10: An internal acknowledge and a refresh or release grant may be high in the same cycle.
- R11: When parameter `HAS_DMA` is 0, `dma_req` is ignored and `dma_ack` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_end | input | 1 | Bus-cycle boundary; internal arbitration point |
| dma_req | input | 1 | DMA controller bus request |
| dtc_req | input | 1 | Data-transfer controller bus request |
| cpu_req | input | 1 | CPU bus request |
| dma_ack | output | 1 | DMA controller acknowledge |
| dtc_ack | output | 1 | Data-transfer controller acknowledge |
| cpu_ack | output | 1 | CPU acknowledge |
| int_owner | output | 2 | Internal owner code (CPU=0, DTC=1, DMA=2) |
| iext_req | input | 1 | External access request from the acknowledged internal master |
| brel_req | input | 1 | External bus-release request |
| rfsh_req | input | 1 | Refresh request |
| iext_gnt | output | 1 | External bus granted to the internal master |
| brel_gnt | output | 1 | External bus released |
| rfsh_gnt | output | 1 | External bus granted to refresh |

## Verification
An internal acknowledge and an external refresh or release grant can be high in the same cycle. The bench sets this up by first acknowledging the CPU internally. It then sweeps every combination of the three external requests while the CPU keeps its acknowledge. Each cycle it checks that the external grant is the arithmetically highest requester and that `cpu_ack` stays high beside it. A second copy of the design, built with `HAS_DMA` = 0, sees the same internal sweep, and its expected acknowledges are computed with the DMA request masked off.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_INT = 3;
  localparam int NUM_EXT = 3;
  // internal tier: higher index wins
  localparam int IDX_CPU = 0;
  localparam int IDX_DTC = 1;
  localparam int IDX_DMA = 2;
  // external tier: higher index wins
  localparam int EXT_IMST = 0;
  localparam int EXT_BREL = 1;
  localparam int EXT_RFSH = 2;

  typedef enum logic [1:0] {
    OWN_CPU = 2'd0,
    OWN_DTC = 2'd1,
    OWN_DMA = 2'd2
  } owner_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  // fixed priority, highest index wins
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N-1) begin : g_top
      assign pick[i] = req[i];
    end else begin : g_low
      assign pick[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end
endmodule

// File: rtl/hold_arb.sv
module hold_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eval_en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] pick;
  logic         held;

  prio_pick #(.N(N)) u_pick (.req(req), .pick(pick));

  assign held = |gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt <= '0;
    end else if (held) begin
      if (!(|(gnt & req))) gnt <= '0;
    end else if (eval_en) begin
      gnt <= pick;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R3
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (held && |(gnt & req)) |=> (gnt == $past(gnt))); // R4
  AST_GNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !(|(gnt & req))) |=> !(|gnt)); // R5
  AST_NO_EVAL_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !eval_en) |=> !(|gnt)); // R2
endmodule

// File: rtl/twotier_bus_arb.sv
module twotier_bus_arb
  import arb_pkg::*;
#(
  parameter bit HAS_DMA = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_end,
  input  logic       dma_req,
  input  logic       dtc_req,
  input  logic       cpu_req,
  output logic       dma_ack,
  output logic       dtc_ack,
  output logic       cpu_ack,
  output logic [1:0] int_owner,
  input  logic       iext_req,
  input  logic       brel_req,
  input  logic       rfsh_req,
  output logic       iext_gnt,
  output logic       brel_gnt,
  output logic       rfsh_gnt
);
  logic [NUM_INT-1:0] int_req, int_ack, int_pick;
  logic [NUM_EXT-1:0] ext_req, ext_gnt;
  logic               any_int_ack;
  owner_e             owner_q;

  assign int_req[IDX_CPU] = cpu_req;
  assign int_req[IDX_DTC] = dtc_req;
  assign int_req[IDX_DMA] = HAS_DMA ? dma_req : 1'b0;

  hold_arb #(.N(NUM_INT)) u_int_tier (
    .clk(clk), .rst_n(rst_n), .eval_en(cycle_end),
    .req(int_req), .gnt(int_ack)
  );

  // owner code copy, parks on the CPU when arbitration finds nobody
  prio_pick #(.N(NUM_INT)) u_own_pick (.req(int_req), .pick(int_pick));

  assign any_int_ack = |int_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_CPU;
    end else if (cycle_end && !any_int_ack) begin
      if (int_pick[IDX_DMA])      owner_q <= OWN_DMA;
      else if (int_pick[IDX_DTC]) owner_q <= OWN_DTC;
      else                        owner_q <= OWN_CPU;
    end
  end

  assign ext_req[EXT_IMST] = iext_req & any_int_ack;
  assign ext_req[EXT_BREL] = brel_req;
  assign ext_req[EXT_RFSH] = rfsh_req;

  hold_arb #(.N(NUM_EXT)) u_ext_tier (
    .clk(clk), .rst_n(rst_n), .eval_en(1'b1),
    .req(ext_req), .gnt(ext_gnt)
  );

  assign cpu_ack   = int_ack[IDX_CPU];
  assign dtc_ack   = int_ack[IDX_DTC];
  assign dma_ack   = int_ack[IDX_DMA];
  assign int_owner = owner_q;
  assign iext_gnt  = ext_gnt[EXT_IMST];
  assign brel_gnt  = ext_gnt[EXT_BREL];
  assign rfsh_gnt  = ext_gnt[EXT_RFSH];

  AST_OWNER_MATCH_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |-> (int_owner == OWN_DMA)); // R6
  AST_OWNER_MATCH_DTC: assert property (@(posedge clk) disable iff (!rst_n)
    dtc_ack |-> (int_owner == OWN_DTC)); // R6
  AST_EXT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iext_gnt, brel_gnt, rfsh_gnt})); // R8
  AST_IEXT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iext_gnt)) |-> $past(cpu_ack | dtc_ack | dma_ack)); // R9
  AST_ACK_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_ack | dtc_ack | dma_ack) |-> $past(cycle_end)); // R2
  AST_NO_DMA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_DMA |-> !dma_ack); // R11
endmodule

// File: tb/twotier_bus_arb_bench.sv
module twotier_bus_arb_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_end = 1'b0;
  logic dma_req = 1'b0, dtc_req = 1'b0, cpu_req = 1'b0;
  logic iext_req = 1'b0, brel_req = 1'b0, rfsh_req = 1'b0;
  logic dma_ack, dtc_ack, cpu_ack, iext_gnt, brel_gnt, rfsh_gnt;
  logic [1:0] int_owner;
  logic n_dma_ack, n_dtc_ack, n_cpu_ack, n_iext, n_brel, n_rfsh;
  logic [1:0] n_owner;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twotier_bus_arb u_twotier_bus_arb (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end),
    .dma_req(dma_req), .dtc_req(dtc_req), .cpu_req(cpu_req),
    .dma_ack(dma_ack), .dtc_ack(dtc_ack), .cpu_ack(cpu_ack),
    .int_owner(int_owner), .iext_req(iext_req), .brel_req(brel_req),
    .rfsh_req(rfsh_req), .iext_gnt(iext_gnt), .brel_gnt(brel_gnt),
    .rfsh_gnt(rfsh_gnt)
  );

  twotier_bus_arb #(.HAS_DMA(1'b0)) u_nodma (
    .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end),
    .dma_req(dma_req), .dtc_req(dtc_req), .cpu_req(cpu_req),
    .dma_ack(n_dma_ack), .dtc_ack(n_dtc_ack), .cpu_ack(n_cpu_ack),
    .int_owner(n_owner), .iext_req(iext_req), .brel_req(brel_req),
    .rfsh_req(rfsh_req), .iext_gnt(n_iext), .brel_gnt(n_brel),
    .rfsh_gnt(n_rfsh)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] top_bit(input logic [2:0] v);
    return v[2] ? 3'b100 : (v[1] ? 3'b010 : (v[0] ? 3'b001 : 3'b000));
  endfunction

  function automatic logic [1:0] code_of(input logic [2:0] v);
    return v[2] ? 2'd2 : (v[1] ? 2'd1 : 2'd0);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R6 reset acks/owner", {dma_ack, dtc_ack, cpu_ack, 1'b0}, 4'b0000);
    check("R6 reset owner", {2'b00, int_owner}, 4'd0);
    check("R8 reset ext grants", {1'b0, rfsh_gnt, brel_gnt, iext_gnt}, 4'b0000);

    // R1 R3 R6 R11: sweep all internal request patterns at a boundary
    for (int v = 0; v < 8; v++) begin
      logic [2:0] pat;
      pat = v[2:0];
      {dma_req, dtc_req, cpu_req} = pat;
      cycle_end = 1'b1;
      tick();
      check($sformatf("R1 R3 acks pat=%b", pat), {1'b0, dma_ack, dtc_ack, cpu_ack}, {1'b0, top_bit(pat)});
      check($sformatf("R6 owner pat=%b", pat), {2'b00, int_owner}, {2'b00, code_of(pat)});
      check($sformatf("R11 nodma acks pat=%b", pat), {1'b0, n_dma_ack, n_dtc_ack, n_cpu_ack},
            {1'b0, top_bit(pat & 3'b011)});
      check($sformatf("R11 nodma owner pat=%b", pat), {2'b00, n_owner}, {2'b00, code_of(pat & 3'b011)});
      {dma_req, dtc_req, cpu_req} = 3'b000;
      cycle_end = 1'b0;
      tick();
      check($sformatf("R5 drop pat=%b", pat), {1'b0, dma_ack, dtc_ack, cpu_ack}, 4'b0000);
    end

    // R2: requests without a boundary are not served
    dtc_req = 1'b1;
    tick();
    tick();
    check("R2 no boundary no ack", {1'b0, dma_ack, dtc_ack, cpu_ack}, 4'b0000);
    cycle_end = 1'b1;
    tick();
    check("R2 served at boundary", {1'b0, dma_ack, dtc_ack, cpu_ack}, 4'b0010);
    dtc_req = 1'b0;
    cycle_end = 1'b0;
    tick();

    // R4: held CPU grant is not preempted by DMA
    cpu_req = 1'b1;
    cycle_end = 1'b1;
    tick();
    dma_req = 1'b1;
    tick();
    tick();
    check("R4 hold against dma", {1'b0, dma_ack, dtc_ack, cpu_ack}, 4'b0001);
    // R5: drop, ack falls, dma only at a later boundary
    cpu_req = 1'b0;
    tick();
    check("R5 ack falls one clock later", {1'b0, dma_ack, dtc_ack, cpu_ack}, 4'b0000);
    tick();
    check("R5 dma at next boundary", {1'b0, dma_ack, dtc_ack, cpu_ack}, 4'b0100);
    dma_req = 1'b0;
    cycle_end = 1'b0;
    tick();

    // R7 R10: CPU holds internal bus while external requests are swept
    cpu_req = 1'b1;
    cycle_end = 1'b1;
    tick();
    cycle_end = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] pat;
      pat = v[2:0];
      {rfsh_req, brel_req, iext_req} = pat;
      tick();
      check($sformatf("R7 ext grant pat=%b", pat), {1'b0, rfsh_gnt, brel_gnt, iext_gnt}, {1'b0, top_bit(pat)});
      check($sformatf("R10 cpu ack overlaps pat=%b", pat), {3'b000, cpu_ack}, 4'b0001);
      {rfsh_req, brel_req, iext_req} = 3'b000;
      tick();
      check($sformatf("R8 ext drop pat=%b", pat), {1'b0, rfsh_gnt, brel_gnt, iext_gnt}, 4'b0000);
    end

    // R8: release grant held against a refresh request
    brel_req = 1'b1;
    tick();
    rfsh_req = 1'b1;
    tick();
    check("R8 release held", {1'b0, rfsh_gnt, brel_gnt, iext_gnt}, 4'b0010);
    brel_req = 1'b0;
    tick();
    check("R8 release falls", {1'b0, rfsh_gnt, brel_gnt, iext_gnt}, 4'b0000);
    tick();
    check("R8 refresh follows", {1'b0, rfsh_gnt, brel_gnt, iext_gnt}, 4'b0100);
    rfsh_req = 1'b0;
    tick();

    // R9: no internal ack, internal external access ignored
    cpu_req = 1'b0;
    tick();
    iext_req = 1'b1;
    tick();
    tick();
    check("R9 iext without ack", {1'b0, rfsh_gnt, brel_gnt, iext_gnt}, 4'b0000);
    iext_req = 1'b0;
    tick();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule